// File: doc/BRIEF.md
# Legacy IDE I/O Access Trap

This block watches the legacy I/O cycles a host issues toward the two ATA channels. It raises a system-management interrupt request when a cycle lands in a channel's command/control window and software has enabled trapping for the drive that is currently selected on that channel. Firmware then handles the access in place of real drive hardware. The block follows drive selection itself. It records bit 4 of every write to a channel's device/head port, so each trap is attributed to drive 0 or drive 1 of that channel.

Software reaches two 8-bit registers through a small register port. The trap-enable register holds one bit per channel/drive pair. The trap-status register holds a sticky flag per pair, and writing a one to a flag clears it. The interrupt request output is active low. It stays asserted while any status flag is set whose enable bit is also set.

Top module: `ide_io_trap`

## Requirements
- R1: After reset, the enable and status registers read 00h, the interrupt request `smi_n` is high, and both channels have drive 0 selected.
- R2: An I/O access (read or write) traps on the primary channel at addresses 1F0h–1F7h and 3F6h. It traps on the secondary channel at 170h–177h and 376h. The trap/status bit index is channel*2 + drive: bit 0 primary drive 0, bit 1 primary drive 1, bit 2 secondary drive 0, bit 3 secondary drive 1.
- R3: An in-window access sets only the status bit for the drive currently selected on that channel, and only when that drive's enable bit is set. The bit is set in the clock edge that samples the access.
- R4: A write to 1F6h (primary) or 176h (secondary) selects drive `io_wdata[4]` on that channel from the next cycle onward. A read of those ports does not change the selection.
- R5: The device/head write that changes the selection is itself matched against the drive that was selected before that write.
- R6: Writing the status register (register address 1) clears each bit written as one and leaves bits written as zero unchanged. A trap arriving in the same cycle as its clear leaves the bit set.
- R7: Bits 7:4 of both registers read as zero whatever value is written. Register address 0 is the enable register, address 1 is the status register, and addresses 2 and 3 read 00h.
- R8: `smi_n` is low exactly while the AND of status and enable is nonzero. It returns high in the cycle after software clears those status bits.
- R9: An access outside both windows never changes the status register or `smi_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strobe | input | 1 | One-cycle I/O access valid |
| io_write | input | 1 | Access is a write (1) or a read (0) |
| io_addr | input | 16 | I/O address of the access |
| io_wdata | input | 8 | I/O write data (bit 4 used for drive selection) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| smi_n | output | 1 | Active-low system-management interrupt request |

## Verification
The hardest condition to reach is the device/head write that changes the drive selection while a trap is pending on only one of the two drives. The result depends on state that no port shows: the old selection. To reach it, the bench sets drive selections while all enables are off, so those writes leave no status behind. It then enables exactly one drive and issues the selecting write. The status read that follows tells whether the trap was checked against the old selection or the new one. The bench also sweeps every address from 000h to 3FFh under three drive-selection patterns. For every enable mask, it tests each channel/drive pair against a status value worked out in the bench.

// File: rtl/ide_trap_pkg.sv
package ide_trap_pkg;

    localparam int IO_AW      = 16;
    localparam int REG_W      = 8;
    localparam int REG_AW     = 2;
    localparam int NUM_CH     = 2;
    localparam int DRV_PER_CH = 2;
    localparam int NUM_TRAP   = NUM_CH * DRV_PER_CH;
    localparam int DRV_BIT    = 4;
    localparam int DEVHEAD_OFS = 6;
    localparam int BLK_LSB    = 3;

    localparam logic [IO_AW-1:0] PRI_CMD_BASE = 16'h01F0;
    localparam logic [IO_AW-1:0] PRI_CTL_PORT = 16'h03F6;
    localparam logic [IO_AW-1:0] SEC_CMD_BASE = 16'h0170;
    localparam logic [IO_AW-1:0] SEC_CTL_PORT = 16'h0376;

    typedef enum logic [REG_AW-1:0] {
        RSEL_ENABLE = 2'd0,
        RSEL_STATUS = 2'd1
    } reg_sel_e;

    typedef struct packed {
        logic hit;      // access falls in this channel's window
        logic dh_wr;    // write to this channel's device/head port
    } win_res_t;

    function automatic logic [IO_AW-1:0] cmd_base(input int ch);
        return (ch == 0) ? PRI_CMD_BASE : SEC_CMD_BASE;
    endfunction

    function automatic logic [IO_AW-1:0] ctl_port(input int ch);
        return (ch == 0) ? PRI_CTL_PORT : SEC_CTL_PORT;
    endfunction

    function automatic logic in_cmd_block(input logic [IO_AW-1:0] a,
                                          input logic [IO_AW-1:0] base);
        return a[IO_AW-1:BLK_LSB] == base[IO_AW-1:BLK_LSB];
    endfunction

endpackage

// File: rtl/ide_window_decode.sv
module ide_window_decode
    import ide_trap_pkg::*;
#(
    parameter logic [IO_AW-1:0] CMD_BASE = PRI_CMD_BASE,
    parameter logic [IO_AW-1:0] CTL_PORT = PRI_CTL_PORT
) (
    input  logic             io_strobe,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_addr,
    output win_res_t         res
);
    localparam logic [IO_AW-1:0] DH_PORT = CMD_BASE + IO_AW'(DEVHEAD_OFS);

    always_comb begin
        res.hit   = io_strobe && (in_cmd_block(io_addr, CMD_BASE) || io_addr == CTL_PORT);
        res.dh_wr = io_strobe && io_write && (io_addr == DH_PORT);
    end
endmodule

// File: rtl/ide_drive_track.sv
module ide_drive_track (
    input  logic clk,
    input  logic rst,
    input  logic dh_wr,
    input  logic sel_in,
    output logic drv
);
    always_ff @(posedge clk) begin
        if (rst)        drv <= 1'b0;
        else if (dh_wr) drv <= sel_in;
    end

    // R4
    drv_change_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(drv) |-> $past(dh_wr));
endmodule

// File: rtl/ide_trap_regs.sv
module ide_trap_regs
    import ide_trap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRAP-1:0] trap_req,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [NUM_TRAP-1:0] reg_wbits,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                smi_n
);
    logic [NUM_TRAP-1:0] en_q, st_q, clr_mask, set_mask;
    logic                wr_en, wr_st;

    always_comb begin
        wr_en    = reg_we && (reg_addr == RSEL_ENABLE);
        wr_st    = reg_we && (reg_addr == RSEL_STATUS);
        clr_mask = wr_st ? reg_wbits : '0;
        set_mask = trap_req & en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (wr_en) en_q <= reg_wbits;
            st_q <= (st_q & ~clr_mask) | set_mask;
        end
    end

    always_comb begin
        case (reg_addr)
            RSEL_ENABLE: reg_rdata = REG_W'(en_q);
            RSEL_STATUS: reg_rdata = REG_W'(st_q);
            default:     reg_rdata = '0;
        endcase
        smi_n = ~|(st_q & en_q);
    end

    // R6
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(st_q) & ~st_q)) |-> $past(wr_st));

    // R3
    status_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|(~$past(st_q) & st_q)) |-> $past(trap_req != '0));

    // R8
    smi_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(smi_n) |-> $past((trap_req != '0) || wr_en));
endmodule

// File: rtl/ide_io_trap.sv
module ide_io_trap
    import ide_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              io_strobe,
    input  logic              io_write,
    input  logic [15:0]       io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              smi_n
);
    win_res_t            win   [NUM_CH];
    logic [NUM_CH-1:0]   drv_sel;
    logic [NUM_CH-1:0]   win_hit;
    logic [NUM_TRAP-1:0] trap_req;
    logic                unused_io_wdata;
    logic                unused_reg_wdata_hi;

    assign unused_io_wdata     = ^{io_wdata[REG_W-1:DRV_BIT+1], io_wdata[DRV_BIT-1:0]};
    assign unused_reg_wdata_hi = ^reg_wdata[REG_W-1:NUM_TRAP];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        ide_window_decode #(
            .CMD_BASE (cmd_base(ch)),
            .CTL_PORT (ctl_port(ch))
        ) dec_i (
            .io_strobe (io_strobe),
            .io_write  (io_write),
            .io_addr   (io_addr),
            .res       (win[ch])
        );

        ide_drive_track trk_i (
            .clk    (clk),
            .rst    (rst),
            .dh_wr  (win[ch].dh_wr),
            .sel_in (io_wdata[DRV_BIT]),
            .drv    (drv_sel[ch])
        );

        assign win_hit[ch] = win[ch].hit;

        for (genvar d = 0; d < DRV_PER_CH; d++) begin : g_drv
            assign trap_req[ch*DRV_PER_CH + d] = win[ch].hit && (drv_sel[ch] == 1'(d));
        end
    end

    ide_trap_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .trap_req  (trap_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wbits (reg_wdata[NUM_TRAP-1:0]),
        .reg_rdata (reg_rdata),
        .smi_n     (smi_n)
    );

    // R2
    windows_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_hit));

    // R9
    out_of_window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && win_hit == '0) |-> trap_req == '0);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7:4] == 4'h0);
endmodule

// File: tb/ide_io_trap_tb_top.sv
module ide_io_trap_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_strobe = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        smi_n;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [3:0] m_en, m_st;
    logic [1:0] m_drv;

    always #5 clk = ~clk;

    ide_io_trap dut_i (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .io_write(io_write),
        .io_addr(io_addr), .io_wdata(io_wdata), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smi_n(smi_n)
    );

    function automatic int chan_of(input logic [15:0] a);
        if ((a >= 16'h1F0 && a <= 16'h1F7) || a == 16'h3F6) return 0;
        if ((a >= 16'h170 && a <= 16'h177) || a == 16'h376) return 1;
        return -1;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_regs(input string req);
        logic [7:0] v;
        rd(2'd0, v); check(req, v, {4'h0, m_en});
        rd(2'd1, v); check(req, v, {4'h0, m_st});
        check(req, {7'h0, smi_n}, {7'h0, ~|(m_st & m_en)});
    endtask

    task automatic io_acc(input logic [15:0] a, input logic wr, input logic [7:0] d);
        int ch;
        ch = chan_of(a);
        if (ch >= 0 && m_en[ch*2 + m_drv[ch]]) m_st[ch*2 + m_drv[ch]] = 1'b1;
        if (wr && ch >= 0 && (a == 16'h1F6 || a == 16'h176)) m_drv[ch] = d[4];
        io_addr = a; io_write = wr; io_wdata = d; io_strobe = 1'b1;
        @(posedge clk); #1;
        io_strobe = 1'b0; io_write = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd0) m_en = d[3:0];
        if (a == 2'd1) m_st = m_st & ~d[3:0];
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic set_drives(input logic p, input logic s);
        logic [3:0] keep;
        keep = m_en;
        reg_wr(2'd0, 8'h00);
        io_acc(16'h1F6, 1'b1, {3'b0, p, 4'h0});
        io_acc(16'h176, 1'b1, {3'b0, s, 4'h0});
        reg_wr(2'd0, {4'h0, keep});
    endtask

    initial begin
        logic [7:0] v;
        m_en = '0; m_st = '0; m_drv = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk_regs("R1");
        rd(2'd2, v); check("R7", v, 8'h00);
        rd(2'd3, v); check("R7", v, 8'h00);

        // R7 reserved bits
        reg_wr(2'd0, 8'hFF); chk_regs("R7");
        reg_wr(2'd0, 8'h00);

        // R2 R3 R9 address sweep under three drive patterns
        for (int pat = 0; pat < 3; pat++) begin
            set_drives(pat[0], pat[1] | pat[0]);
            reg_wr(2'd0, 8'h0F);
            for (int a = 0; a < 16'h400; a++) begin
                io_acc(16'(a), 1'b0, 8'h00);
                if (chan_of(16'(a)) < 0) chk_regs("R9");
                else chk_regs("R2");
                reg_wr(2'd1, 8'hFF);
            end
            chk_regs("R8");
        end

        // R3 every enable mask, every channel/drive pair
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 4; p++) begin
                set_drives(p[0], p[0]);
                reg_wr(2'd0, 8'(e));
                io_acc(p[1] ? 16'h376 : 16'h3F6, 1'b0, 8'h00);
                chk_regs("R3");
                reg_wr(2'd1, 8'h0F);
            end
        end

        // R4 read of device/head port does not change selection
        set_drives(1'b0, 1'b0);
        reg_wr(2'd0, 8'h00);
        io_acc(16'h1F6, 1'b0, 8'h10);
        reg_wr(2'd0, 8'h02);
        io_acc(16'h1F0, 1'b0, 8'h00);
        chk_regs("R4");
        reg_wr(2'd1, 8'hFF);

        // R5 selecting write checked against prior selection
        reg_wr(2'd0, 8'h02);
        io_acc(16'h1F6, 1'b1, 8'h10);
        chk_regs("R5");
        io_acc(16'h1F2, 1'b1, 8'h00);
        chk_regs("R5");
        reg_wr(2'd1, 8'hFF);
        reg_wr(2'd0, 8'h04);
        io_acc(16'h176, 1'b1, 8'h10);
        chk_regs("R5");
        reg_wr(2'd1, 8'hFF);
        reg_wr(2'd0, 8'h08);
        io_acc(16'h176, 1'b1, 8'h00);
        chk_regs("R5");
        reg_wr(2'd1, 8'hFF);

        // R6 write zero keeps, write one clears, set wins over clear
        set_drives(1'b0, 1'b0);
        reg_wr(2'd0, 8'h05);
        io_acc(16'h1F1, 1'b0, 8'h00);
        io_acc(16'h171, 1'b0, 8'h00);
        chk_regs("R6");
        reg_wr(2'd1, 8'h00); chk_regs("R6");
        reg_wr(2'd1, 8'h04); chk_regs("R6");
        reg_addr = 2'd1; reg_wdata = 8'h01; reg_we = 1'b1;
        io_addr = 16'h3F6; io_write = 1'b0; io_strobe = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; io_strobe = 1'b0;
        chk_regs("R6");

        // R8 smi follows status&enable, releases after clear
        reg_wr(2'd0, 8'h00); chk_regs("R8");
        reg_wr(2'd0, 8'h01); chk_regs("R8");
        reg_wr(2'd1, 8'h01); chk_regs("R8");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule